// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous 8K x 8 static RAM that has one active-low and one active-high chip select. The host offers one word at a time through a valid/ready handshake with a write flag, a 13-bit address and 8-bit write data. The block turns each request into a control sequence on the memory pins whose pulse widths meet the memory's minimum timing. Read results come back with a one-cycle done strobe.

Every minimum time is turned into a whole number of clock cycles when the design is elaborated. Each time is divided by the clock period and the result is rounded up. The clock period and the memory speed grade (100, 120 or 150 ns) are both parameters.

A read asserts both selects and the output enable for the access time. The data bus is sampled at the end of that window. A write pulses the write enable while the output enable stays high, so the memory never drives the bus while the block does. The selects and the driven data are then held for a recovery stretch. After every access both selects go inactive for a turnaround gap. The bus is shared through separate in, out and enable ports.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, req_ready is 1, mem_cs1_n is 1, mem_cs2 is 0, mem_we_n is 1, mem_oe_n is 1, mem_dq_oe is 0 and rsp_done is 0.
- R2: A read holds both selects active (mem_cs1_n 0, mem_cs2 1), mem_oe_n low, mem_we_n high and mem_addr stable for NRD cycles. rsp_done is a single-cycle pulse that is visible NRD cycles after the accepting clock edge.
- R3: rsp_rdata equals the word the memory presents on mem_dq_in during the last cycle of the read window. It is valid in the cycle rsp_done is 1.
- R4: A write holds mem_we_n low for exactly NWP consecutive cycles. During those cycles the selects are active, mem_oe_n is 1, mem_dq_oe is 1, and mem_dq_out carries the accepted write data unchanged.
- R5: After mem_we_n rises, the selects stay active and the data stays driven for NWREC cycles. mem_dq_oe then drops in the same cycle as the selects.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0.
- R7: After any access, the selects stay inactive for at least NTURN cycles. When the next request is already waiting, the gap is exactly NTURN+1 cycles, because one idle cycle is spent accepting it.
- R8: A request is taken only on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 while an access is in progress. Address, data and write flag are captured at acceptance, and later changes to the request inputs do not affect that access.
- R9: The cycle counts are computed by rounding up time divided by the clock period. NRD is the grade time. NWP is the largest of the write pulse, select-to-end, address-to-end and data setup times. NWREC is the write cycle count minus NWP, with a minimum of 1. NTURN is the output release time, with a minimum of 1. For the 100 ns grade with a 20 ns clock, NRD=5, NWP=4, NWREC=1 and NTURN=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data |
| rsp_done | output | 1 | One-cycle pulse: rsp_rdata valid |
| mem_addr | output | 13 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
A sequencer stuck in or skipping a state shows at once as a wrong pin pattern: a write enable pulse of the wrong length, an output enable low during a write, or a turnaround gap that is one cycle short. The next access boundary exposes it. A counter loaded with the wrong value moves the read sample point. The memory model presents inverted data until the access time has elapsed, so early sampling returns a wrong word at the very next done pulse. The done pulse is also timed against the accepting edge. A capture register that follows the host inputs instead of holding them shows up as corrupted data when the word is read back.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_WPULSE = 3'd2,
      ST_WREC   = 3'd3,
      ST_TURN   = 3'd4
   } asram_state_e;

   localparam int TK_CYCLE   = 0;
   localparam int TK_WPULSE  = 1;
   localparam int TK_SELEND  = 2;
   localparam int TK_DSETUP  = 3;
   localparam int TK_RELEASE = 4;

   function automatic int grade_time(input int grade, input int kind);
      int t;
      t = grade;
      case (kind)
         TK_CYCLE:   t = grade;
         TK_WPULSE:  t = (grade == 100) ? 60 : (grade == 120) ? 70 : 90;
         TK_SELEND:  t = (grade == 100) ? 80 : (grade == 120) ? 85 : 100;
         TK_DSETUP:  t = (grade == 150) ? 50 : 40;
         TK_RELEASE: t = (grade == 100) ? 35 : (grade == 120) ? 40 : 50;
         default:    t = grade;
      endcase
      return t;
   endfunction

   function automatic int ceil_cycles(input int ns, input int period);
      return (ns + period - 1) / period;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int cnt_bits(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/asram_dcount.sv
module asram_dcount #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   a_r9_count_down : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int NRD   = 5,
   parameter int NWP   = 4,
   parameter int NWREC = 1,
   parameter int NTURN = 2,
   parameter int CNT_W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         start_write,
   output asram_state_e nxt,
   output logic         capture
);
   asram_state_e st_q;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             zero;

   asram_dcount #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
   );

   always_comb begin
      nxt      = st_q;
      load     = 1'b0;
      load_val = '0;
      unique case (st_q)
         ST_IDLE: if (start) begin
            load     = 1'b1;
            nxt      = start_write ? ST_WPULSE : ST_READ;
            load_val = start_write ? CNT_W'(NWP - 1) : CNT_W'(NRD - 1);
         end
         ST_READ: if (zero) begin
            nxt = ST_TURN; load = 1'b1; load_val = CNT_W'(NTURN - 1);
         end
         ST_WPULSE: if (zero) begin
            nxt = ST_WREC; load = 1'b1; load_val = CNT_W'(NWREC - 1);
         end
         ST_WREC: if (zero) begin
            nxt = ST_TURN; load = 1'b1; load_val = CNT_W'(NTURN - 1);
         end
         ST_TURN: if (zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   assign capture = (st_q == ST_READ) && zero;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= nxt;
   end

   // R2: a read window always ends in the turnaround state
   a_r2_read_to_turn : assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (st_q == ST_TURN));

   // R7: the sequencer reaches idle only through the turnaround state
   a_r7_idle_via_turn : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) ##1 (st_q == ST_IDLE) |-> ($past(st_q) == ST_TURN));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 20,
   parameter int GRADE_NS      = 100,
   parameter int AW            = 13,
   parameter int DW            = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_done,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs1_n,
   output logic          mem_cs2,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);
   localparam int P      = CLK_PERIOD_NS;
   localparam int NRD    = ceil_cycles(grade_time(GRADE_NS, TK_CYCLE), P);
   localparam int NWP    = imax(ceil_cycles(grade_time(GRADE_NS, TK_WPULSE), P),
                           imax(ceil_cycles(grade_time(GRADE_NS, TK_SELEND), P),
                                ceil_cycles(grade_time(GRADE_NS, TK_DSETUP), P)));
   localparam int NWC    = ceil_cycles(grade_time(GRADE_NS, TK_CYCLE), P);
   localparam int NWREC  = imax(1, NWC - NWP);
   localparam int NTURN  = imax(1, ceil_cycles(grade_time(GRADE_NS, TK_RELEASE), P));
   localparam int CNT_W  = cnt_bits(imax(imax(NRD, NWP), imax(NWREC, NTURN)) + 1);

   initial begin
      a_grade_legal : assert (GRADE_NS == 100 || GRADE_NS == 120 || GRADE_NS == 150);
      a_period_legal : assert (CLK_PERIOD_NS > 0);
      a_width_legal : assert (AW > 0 && DW > 0);
   end

   asram_state_e nxt;
   logic         capture;
   logic         accept;
   logic         ready_q, cs_q, we_q, oe_q, dqoe_q, done_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rdata_q;

   assign accept = req_valid && ready_q;

   asram_seq #(
      .NRD(NRD), .NWP(NWP), .NWREC(NWREC), .NTURN(NTURN), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .start_write(req_write),
      .nxt(nxt), .capture(capture)
   );

   // pin registers decoded from the next state so every pin leaves a flop
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b1;
         cs_q    <= 1'b0;
         we_q    <= 1'b0;
         oe_q    <= 1'b0;
         dqoe_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         ready_q <= (nxt == ST_IDLE);
         cs_q    <= (nxt == ST_READ) || (nxt == ST_WPULSE) || (nxt == ST_WREC);
         we_q    <= (nxt == ST_WPULSE);
         oe_q    <= (nxt == ST_READ);
         dqoe_q  <= (nxt == ST_WPULSE) || (nxt == ST_WREC);
         done_q  <= capture;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= mem_dq_in;
      end
   end

   assign req_ready  = ready_q;
   assign mem_addr   = addr_q;
   assign mem_cs1_n  = ~cs_q;
   assign mem_cs2    = cs_q;
   assign mem_we_n   = ~we_q;
   assign mem_oe_n   = ~oe_q;
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = dqoe_q;
   assign rsp_rdata  = rdata_q;
   assign rsp_done   = done_q;

   // checker counters for pulse widths
   logic [CNT_W:0] we_len, idle_len;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_len   <= '0;
         idle_len <= (CNT_W+1)'(NTURN + 1);
      end else begin
         we_len <= !mem_we_n ? we_len + 1'b1 : '0;
         if (cs_q)                            idle_len <= '0;
         else if (idle_len < (CNT_W+1)'(NTURN + 1)) idle_len <= idle_len + 1'b1;
      end
   end

   a_r4_we_width : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_len == (CNT_W+1)'(NWP)));
   a_r4_oe_high_in_write : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_cs1_n && mem_cs2 && mem_dq_oe));
   a_r5_hold_after_we : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs1_n && $stable(mem_dq_out)));
   a_r5_release_with_sel : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe) |-> (mem_cs1_n && !mem_cs2));
   a_r6_no_bus_fight : assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);
   a_r2_addr_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));
   a_r2_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   a_r7_turn_gap : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs1_n) |-> (idle_len >= (CNT_W+1)'(NTURN)));
   a_r8_busy_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs1_n |-> !req_ready);

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
   localparam int E_RD    = (100 + 19) / 20;
   localparam int E_WP    = (80 + 19) / 20;
   localparam int E_WREC  = 1;
   localparam int E_TURN  = (35 + 19) / 20;
   localparam int WD_LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rsp_done;
   logic [7:0] rsp_rdata;
   logic [12:0] mem_addr;
   logic mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0] mem_dq_out;
   logic [7:0] mem_dq_in = 8'h5A;

   asram_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   always #10 clk = ~clk;

   int nchk = 0, nfail = 0, cyc = 0;
   bit finished = 0;
   logic [7:0] ram [int];
   logic [7:0] shadow [int];
   logic [7:0] exp_q [$];
   int lat_q [$];

   function automatic logic [7:0] init_val(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], 3'b101};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT && !finished) begin
         finished = 1;
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   // memory model and pin-timing monitor
   int age = 0, wlen = 0, rec = 0, idle = 0;
   bit in_rec = 0, had_acc = 0, wbad = 0;
   logic [12:0] prev_addr = '0;
   logic [7:0] wlatch = '0;
   always @(negedge clk) begin
      logic sel;
      logic [7:0] cur;
      sel = !mem_cs1_n && mem_cs2;
      if (rst_n) begin
         cur = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_val(mem_addr);
         if (sel && !mem_oe_n && mem_we_n) begin
            age = (age > 0 && mem_addr == prev_addr) ? age + 1 : 1;
            mem_dq_in = (age >= E_RD) ? cur : ~cur;
         end else begin
            age = 0;
            mem_dq_in = 8'h5A;
         end
         prev_addr = mem_addr;
         if (sel && !mem_we_n) begin
            if (!mem_oe_n || !mem_dq_oe) wbad = 1;
            if (wlen > 0 && mem_dq_out != wlatch) wbad = 1;
            wlatch = mem_dq_out;
            wlen++;
         end else if (wlen > 0) begin
            chk(wlen == E_WP, "R4 we_n low width", wlen, E_WP);
            chk(!wbad, "R4 oe_n high, data driven and stable during write", wbad, 0);
            chk(sel && mem_dq_oe && mem_dq_out == wlatch, "R5 hold after we_n rise",
                {sel, mem_dq_oe}, 2'b11);
            ram[int'(mem_addr)] = wlatch;
            wlen = 0; wbad = 0; in_rec = 1; rec = 1;
         end else if (in_rec && sel) begin
            rec++;
         end else if (in_rec && !sel) begin
            chk(rec == E_WREC, "R5 recovery length", rec, E_WREC);
            chk(!mem_dq_oe, "R5 dq_oe drops with selects", mem_dq_oe, 0);
            in_rec = 0;
         end
         if (mem_dq_oe && !mem_oe_n) chk(0, "R6 bus fight", 1, 0);
         if (!sel) idle++;
         else begin
            if (idle > 0 && had_acc && req_valid_at_gap)
               chk(idle == E_TURN + 1, "R7 turnaround gap back-to-back", idle, E_TURN + 1);
            else if (idle > 0 && had_acc)
               chk(idle >= E_TURN, "R7 turnaround gap minimum", idle, E_TURN);
            had_acc = 1;
            idle = 0;
         end
      end
   end

   bit req_valid_at_gap = 0;
   always @(negedge clk) begin
      if (mem_cs1_n && !req_ready) req_valid_at_gap = req_valid;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (exp_q.size() == 0) begin
            chk(0, "R8 done without pending read", 1, 0);
         end else begin
            logic [7:0] e;
            int a;
            e = exp_q.pop_front();
            a = lat_q.pop_front();
            chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
            chk(cyc - a == E_RD, "R2 R9 read latency", cyc - a, E_RD);
         end
      end
   end

   task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      if (wr) shadow[int'(a)] = d;
      else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a));
      while (!req_ready) @(negedge clk);
      if (!wr) lat_q.push_back(cyc + 1);
      @(negedge clk);
      req_valid = 0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic drain();
      int n = 0;
      while ((exp_q.size() != 0 || !req_ready) && n < 200) begin
         @(negedge clk); n++;
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done,
          "R1 reset state", {req_ready, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done},
          7'b1101100);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 first cycle after reset", {req_ready, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe},
          6'b110110);
      // R3 reads of untouched words
      issue(0, 13'h0000, 0);
      issue(0, 13'h1FFF, 0);
      drain();
      // R4 R5 writes with several patterns, back-to-back (R7)
      issue(1, 13'h0000, 8'h00);
      issue(1, 13'h1FFF, 8'hFF);
      issue(1, 13'h0155, 8'hA5);
      issue(1, 13'h0AAA, 8'h5A);
      // R8 read-after-write with inputs changed after acceptance
      issue(0, 13'h0000, 0);
      issue(0, 13'h1FFF, 0);
      issue(0, 13'h0155, 0);
      issue(0, 13'h0AAA, 0);
      drain();
      // alternating write and read of the same word
      for (int i = 0; i < 6; i++) begin
         issue(1, 13'(i * 13'h0333), 8'(8'h11 * i + 3));
         issue(0, 13'(i * 13'h0333), 0);
      end
      drain();
      // R8 valid held while busy must not start a second access
      req_valid = 1; req_write = 1; req_addr = 13'h0042; req_wdata = 8'hC3;
      while (!req_ready) @(negedge clk);
      shadow[32'h42] = 8'hC3;
      @(negedge clk);
      req_wdata = 8'h3C; req_addr = 13'h0043;
      req_valid = 0;
      @(negedge clk);
      chk(!req_ready, "R8 not ready while busy", req_ready, 0);
      drain();
      issue(0, 13'h0042, 0);
      issue(0, 13'h0043, 0);
      drain();
      chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end
endmodule